// File: doc/BRIEF.md
# Directory transactional mark handler

This block is the transactional part of one directory slice. For every line in the slice it stores a vector with one bit per core, marking the cores that share the line. It also stores one bit per line that shows the line is in use by a transaction. A core running a transaction asks for a line by sending a mark request in place of an ordinary shared or exclusive fetch. The handler adds the core to the line's sharers. It then tells every other sharer which core has just joined, so that each sharer can update its own conflict bookkeeping. Last, it acknowledges the requester with the number of other sharers it found.

Notifications go out one per cycle, starting at the lowest core ID. The acknowledgement follows only after the last notification has been taken. While a mark is in progress the request port is not ready, so any later request waits. A release request is sent when a transaction commits or aborts. It removes the core from the sharer vector and clears the line's transactional bit once no sharer is left. Every channel uses a valid/ready handshake. A message is taken on a rising clock edge at which both valid and ready are high.

Top module: `dtm_mark_dir`

## Requirements
- R1: While reset is held and just after it is released, `ntf_valid` and `ack_valid` are 0, `req_ready` is 1, and every line has no sharers and a clear transactional bit.
- R2: A mark (`req_op` = 0) on a line that no other core shares sends no notification. Its acknowledgement carries `ack_count` = 0.
- R3: `ack_count` is the number of cores, other than the requester, whose sharer bit was set when the mark was accepted. A requester that already shares the line is not counted.
- R4: A mark sends one notification to each other sharer, in strictly ascending order of `ntf_dest`. Each notification carries the requester in `ntf_accessor` and the line in `ntf_line`.
- R5: The acknowledgement is presented only after every notification of the same mark has completed its handshake. It carries the requester in `ack_core` and the line in `ack_line`.
- R6: `req_ready` is 0 from the cycle after a mark is accepted until its acknowledgement handshake completes. It is 1 otherwise.
- R7: A release (`req_op` = 1) clears the requester's sharer bit on that line. It produces no notification and no acknowledgement, and `req_ready` stays 1. Releasing a core that is not a sharer changes nothing.
- R8: While `ntf_ready` or `ack_ready` is low, the matching valid stays high and its payload stays unchanged.
- R9: An accepted mark records the requester as a sharer, and later marks by other cores count it and notify it.
- R10: `ack_first` is 1 exactly when the line's transactional bit was clear at acceptance. A mark sets the bit. A release clears it once the line has no sharers left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Handler can take a request |
| req_op | input | 1 | 0 = transactional mark, 1 = release on commit or abort |
| req_core | input | $clog2(NUM_CORES) | Requesting core |
| req_line | input | $clog2(NUM_LINES) | Line index within the slice |
| ntf_valid | output | 1 | Accessor notification present |
| ntf_ready | input | 1 | Notification taken |
| ntf_dest | output | $clog2(NUM_CORES) | Sharer that receives the notification |
| ntf_accessor | output | $clog2(NUM_CORES) | Core that has just marked the line |
| ntf_line | output | $clog2(NUM_LINES) | Line concerned |
| ack_valid | output | 1 | Acknowledgement present |
| ack_ready | input | 1 | Acknowledgement taken |
| ack_core | output | $clog2(NUM_CORES) | Requester being acknowledged |
| ack_line | output | $clog2(NUM_LINES) | Line acknowledged |
| ack_count | output | $clog2(NUM_CORES+1) | Number of other sharers |
| ack_first | output | 1 | Line was not transactional before this mark |

## Verification
The assertions assume that whoever consumes the notification and acknowledgement channels may hold ready low for any length of time. They also assume that a request offered while `req_ready` is low is simply not taken. Nothing is assumed about the timing of `req_valid`. Under these assumptions the checker tracks handshakes and confirms the ordering, holding and stall properties.

The stimulus offers each request only on a cycle where `req_ready` is high, and withdraws it after one edge. It keeps core and line indices in range. On one mark it stalls both output channels for several cycles, so that the holding rule is exercised as well as the free-running case.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  typedef enum logic {
    OP_MARK    = 1'b0,
    OP_RELEASE = 1'b1
  } dtm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NOTIFY = 2'd1,
    ST_ACK    = 2'd2
  } dtm_state_e;

endpackage

// File: rtl/dtm_line_store.sv
// Per-line sharer vectors and transactional bits with one read port and one write port.
module dtm_line_store #(
  parameter int NUM_CORES = 32,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINE_W-1:0]    rd_line,
  output logic [NUM_CORES-1:0] rd_vec,
  output logic                 rd_tx,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic [CORE_W-1:0]    wr_core,
  input  logic                 mark_en,
  input  logic                 rel_en
);

  logic [NUM_CORES-1:0] vec_q [NUM_LINES];
  logic                 tx_q  [NUM_LINES];
  logic [NUM_CORES-1:0] core_mask;

  assign core_mask = {{(NUM_CORES-1){1'b0}}, 1'b1} << wr_core;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [NUM_CORES-1:0] vec_d;
    logic                 tx_d;
    logic                 hit;

    assign hit = (wr_line == LINE_W'(g));

    always_comb begin
      vec_d = vec_q[g];
      tx_d  = tx_q[g];
      if (hit && mark_en) begin
        vec_d = vec_q[g] | core_mask;
        tx_d  = 1'b1;
      end else if (hit && rel_en) begin
        vec_d = vec_q[g] & ~core_mask;
        if (vec_d == '0) tx_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[g] <= '0;
        tx_q[g]  <= 1'b0;
      end else if (hit && (mark_en || rel_en)) begin
        vec_q[g] <= vec_d;
        tx_q[g]  <= tx_d;
      end
    end
  end

  assign rd_vec = vec_q[rd_line];
  assign rd_tx  = tx_q[rd_line];

endmodule

// File: rtl/dtm_popcount.sv
// Counts the set bits of a vector.
module dtm_popcount #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count = count + CNT_W'(vec[i]);
    end
  end

endmodule

// File: rtl/dtm_lowest_set.sv
// Finds the index of the lowest set bit.
module dtm_lowest_set #(
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dtm_mark_dir.sv
// Directory slice handler for transactional marks and releases.
module dtm_mark_dir #(
  parameter int NUM_CORES = 32,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int CNT_W  = $clog2(NUM_CORES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [CORE_W-1:0] req_core,
  input  logic [LINE_W-1:0] req_line,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [CORE_W-1:0] ntf_dest,
  output logic [CORE_W-1:0] ntf_accessor,
  output logic [LINE_W-1:0] ntf_line,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [CORE_W-1:0] ack_core,
  output logic [LINE_W-1:0] ack_line,
  output logic [CNT_W-1:0]  ack_count,
  output logic              ack_first
);
  import dtm_pkg::*;

  dtm_state_e state_q, state_d;
  logic [NUM_CORES-1:0] pend_q, pend_d;
  logic [CORE_W-1:0]    core_q;
  logic [LINE_W-1:0]    line_q;
  logic [CNT_W-1:0]     count_q;
  logic                 first_q;

  logic [NUM_CORES-1:0] rd_vec, others, self_mask, dest_mask;
  logic                 rd_tx;
  logic                 accept, do_mark, do_rel;
  logic                 ntf_hs, ack_hs;
  logic [CNT_W-1:0]     others_cnt;
  logic [CORE_W-1:0]    low_idx;
  logic                 low_any;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign do_mark   = accept && (req_op == OP_MARK);
  assign do_rel    = accept && (req_op == OP_RELEASE);

  dtm_line_store #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_line (req_line),
    .rd_vec  (rd_vec),
    .rd_tx   (rd_tx),
    .wr_line (req_line),
    .wr_core (req_core),
    .mark_en (do_mark),
    .rel_en  (do_rel)
  );

  assign self_mask = {{(NUM_CORES-1){1'b0}}, 1'b1} << req_core;
  assign others    = rd_vec & ~self_mask;

  dtm_popcount #(.WIDTH(NUM_CORES)) i_count (
    .vec   (others),
    .count (others_cnt)
  );

  dtm_lowest_set #(.WIDTH(NUM_CORES)) i_pick (
    .vec (pend_q),
    .idx (low_idx),
    .any (low_any)
  );

  assign dest_mask = {{(NUM_CORES-1){1'b0}}, 1'b1} << low_idx;

  assign ntf_valid    = (state_q == ST_NOTIFY) && low_any;
  assign ntf_dest     = low_idx;
  assign ntf_accessor = core_q;
  assign ntf_line     = line_q;
  assign ack_valid    = (state_q == ST_ACK);
  assign ack_core     = core_q;
  assign ack_line     = line_q;
  assign ack_count    = count_q;
  assign ack_first    = first_q;

  assign ntf_hs = ntf_valid && ntf_ready;
  assign ack_hs = ack_valid && ack_ready;

  // next state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (do_mark) begin
          pend_d  = others;
          state_d = (others == '0) ? ST_ACK : ST_NOTIFY;
        end
      end
      ST_NOTIFY: begin
        if (ntf_hs) begin
          pend_d = pend_q & ~dest_mask;
          if (pend_d == '0) state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        if (ack_hs) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q  <= '0;
      line_q  <= '0;
      count_q <= '0;
      first_q <= 1'b0;
    end else if (do_mark) begin
      core_q  <= req_core;
      line_q  <= req_line;
      count_q <= others_cnt;
      first_q <= ~rd_tx;
    end
  end

endmodule

// File: rtl/dtm_mark_dir_chk.sv
module dtm_mark_dir_chk #(
  parameter int NUM_CORES = 32,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int CNT_W  = $clog2(NUM_CORES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ntf_valid,
  input logic              ntf_ready,
  input logic [CORE_W-1:0] ntf_dest,
  input logic [CORE_W-1:0] ntf_accessor,
  input logic [LINE_W-1:0] ntf_line,
  input logic              ack_valid,
  input logic              ack_ready,
  input logic [CORE_W-1:0] ack_core,
  input logic [LINE_W-1:0] ack_line,
  input logic [CNT_W-1:0]  ack_count
);

  logic              burst_q;
  logic [CORE_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      last_q  <= '0;
    end else if (ntf_valid && ntf_ready) begin
      burst_q <= 1'b1;
      last_q  <= ntf_dest;
    end else if (ack_valid && ack_ready) begin
      burst_q <= 1'b0;
    end
  end

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && burst_q) |-> (ntf_dest > last_q));

  a_r4_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (ntf_dest != ntf_accessor));

  a_r5_ack_after_ntf: assert property (@(posedge clk) disable iff (!rst_n)
    !(ntf_valid && ack_valid));

  a_r6_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid || ack_valid) |-> !req_ready);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (32'(ack_count) < NUM_CORES));

  a_r8_ntf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_dest)
      && $stable(ntf_accessor) && $stable(ntf_line)));

  a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_core)
      && $stable(ack_line) && $stable(ack_count)));

endmodule

bind dtm_mark_dir dtm_mark_dir_chk #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) i_chk (.*);

// File: tb/test_dtm_mark_dir.sv
`timescale 1ns/1ps
module test_dtm_mark_dir;
  localparam int NC = 32;
  localparam int NL = 16;
  localparam int CW = $clog2(NC);
  localparam int LW = $clog2(NL);
  localparam int KW = $clog2(NC + 1);

  logic clk, rst_n;
  logic req_valid, req_ready, req_op;
  logic [CW-1:0] req_core;
  logic [LW-1:0] req_line;
  logic ntf_valid, ntf_ready;
  logic [CW-1:0] ntf_dest, ntf_accessor;
  logic [LW-1:0] ntf_line;
  logic ack_valid, ack_ready, ack_first;
  logic [CW-1:0] ack_core;
  logic [LW-1:0] ack_line;
  logic [KW-1:0] ack_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NC-1:0] m_vec [NL];
  logic          m_tx  [NL];

  dtm_mark_dir #(.NUM_CORES(NC), .NUM_LINES(NL)) i_dtm_mark_dir (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_mark(input int core, input int line, input bit stall);
    logic [NC-1:0] oth;
    int exp_list [NC];
    int n_exp, k, guard, cnt;
    bit exp_first, seen_ack;
    oth = m_vec[line] & ~(NC'(1) << core);
    n_exp = 0;
    for (int c = 0; c < NC; c++) if (oth[c]) begin exp_list[n_exp] = c; n_exp++; end
    exp_first = !m_tx[line];
    m_vec[line][core] = 1'b1;
    m_tx[line] = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready before mark", int'(req_ready), 1);
    req_valid = 1'b1; req_op = 1'b0; req_core = CW'(core); req_line = LW'(line);
    if (stall) begin ntf_ready = 1'b0; ack_ready = 1'b0; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R6 stall after mark", int'(req_ready), 0);
    if (stall) begin
      logic [CW-1:0] d0; logic [KW-1:0] c0; bit v0;
      v0 = n_exp > 0 ? ntf_valid : ack_valid;
      d0 = ntf_dest; c0 = ack_count;
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        chk((n_exp > 0 ? ntf_valid : ack_valid) == v0 && v0, "R8 valid held", int'(v0), 1);
        chk(ntf_dest == d0 && ack_count == c0, "R8 payload held", int'(ntf_dest), int'(d0));
      end
      ntf_ready = 1'b1; ack_ready = 1'b1;
    end
    k = 0; guard = 0; seen_ack = 0;
    while (!seen_ack && guard < 100) begin
      guard++;
      if (ntf_valid) begin
        if (k < n_exp) chk(int'(ntf_dest) == exp_list[k], "R4 dest order", int'(ntf_dest), exp_list[k]);
        else chk(0, "R4 extra notification", k, n_exp);
        chk(int'(ntf_accessor) == core, "R4 accessor", int'(ntf_accessor), core);
        chk(int'(ntf_line) == line, "R4 line", int'(ntf_line), line);
        k++;
        @(negedge clk);
      end else if (ack_valid) begin
        seen_ack = 1;
        chk(k == n_exp, "R5 all notified before ack", k, n_exp);
        cnt = n_exp;
        chk(int'(ack_count) == cnt, (n_exp == 0) ? "R2 zero count" : "R3 sharer count", int'(ack_count), cnt);
        chk(int'(ack_core) == core && int'(ack_line) == line, "R5 ack ids", int'(ack_core), core);
        chk(ack_first == exp_first, "R10 first flag", int'(ack_first), int'(exp_first));
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
    chk(seen_ack, "R5 ack seen", int'(seen_ack), 1);
    chk(req_ready == 1'b1, "R6 ready after ack", int'(req_ready), 1);
  endtask

  task automatic do_release(input int core, input int line);
    m_vec[line][core] = 1'b0;
    if (m_vec[line] == '0) m_tx[line] = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b1; req_core = CW'(core); req_line = LW'(line);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ntf_valid && !ack_valid && req_ready, "R7 release silent", int'(ntf_valid || ack_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_core = '0; req_line = '0;
    ntf_ready = 1'b1; ack_ready = 1'b1;
    for (int l = 0; l < NL; l++) begin m_vec[l] = '0; m_tx[l] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(!ntf_valid && !ack_valid && req_ready, "R1 in reset", int'(ntf_valid || ack_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ntf_valid && !ack_valid && req_ready, "R1 after reset", int'(ntf_valid || ack_valid), 0);
  endtask

  task automatic t_single();          // R2, R10
    do_mark(3, 5, 0);
    do_mark(3, 5, 0);                 // R3: self not counted
    do_mark(3, 6, 0);                 // other line independent
  endtask

  task automatic t_sharers();         // R3, R4, R9
    do_mark(7, 5, 0);
    do_mark(31, 5, 0);
    do_mark(0, 5, 0);
    do_mark(20, 5, 1);                // R8 with backpressure
  endtask

  task automatic t_release();         // R7, R10
    do_release(9, 5);                 // not a sharer: no change
    do_release(7, 5);
    do_mark(12, 5, 0);                // 7 no longer counted
    do_release(3, 6);
    do_mark(4, 6, 0);                 // line 6 empty again: first set
    do_release(4, 6);
    do_release(4, 6);
  endtask

  initial begin
    t_reset();
    t_single();
    t_sharers();
    t_release();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule